// File: doc/BRIEF.md
# External Control Word Transfer Unit

This unit carries out one word transfer to or from a special-purpose device for the external-control-in and external-control-out word instructions. The device is not picked by decoding the address. A 4-bit resource ID goes out on a burst line and three size lines that are given a new meaning for these transfers. The translated physical address reaches the device only as an operand.

The unit accepts a request when it is idle and registers every operand at that moment. It checks the effective address for word alignment and the segment for the T bit. If both checks are clean, it raises a bus request and holds it until the device acknowledges. For the in form, the unit returns the device word. For the out form, it drives the store word on the bus. Each request ends with a one-cycle `done` pulse. If the request fails a check, an exception flag is raised together with that pulse.

The state machine has five states:
- IDLE: waiting for a request. It goes to EVAL when it accepts one.
- EVAL: checking the captured request. It goes to FAULT if either check fails, and to XFER if both pass.
- XFER: driving the bus. It stays here until an acknowledge, then goes to FINISH.
- FINISH: the completion pulse. It returns to IDLE.
- FAULT: the exception pulse. It returns to IDLE.

Top module: `ecw_unit`

## Requirements
- R1: After reset, `bus_req`, `done`, `exc_align` and `exc_dsi` are all low.
- R2: While `bus_req` is high:
  - `bus_burst` equals `rid_reg[3]`.
  - `bus_size` equals `rid_reg[2:0]`.
  - These are the four least significant bits captured at acceptance. In most-significant-first numbering these are bits 28 to 31, and bit 28 rides on the burst line.
- R3: A request that passes both checks raises `bus_req` starting two cycles after it is accepted. When `dr_en` was 1, `bus_addr` equals the captured `req_pa`. When `dr_en` was 0, the address value is left unspecified.
- R4: If `req_ea[1:0]` is not 00, the unit does not make a bus transfer. It pulses `done` with `exc_align` high.
- R5: If the address is aligned and `seg_t` is 1, the unit does not make a bus transfer. It pulses `done` with `exc_dsi` high.
- R6: When a request is both misaligned and in a T segment, only `exc_align` is raised. The two exception flags are never high together.
- R7: Once raised, `bus_req` stays high, and the address stays stable, until `bus_ack` is sampled high. `done` pulses for exactly one cycle, in the cycle after that acknowledge.
- R8: The direction flag selects the form:
  - In form (`req_out`=0): `bus_wr` is 0. `rd_data` returns the `bus_rdata` word sampled with the acknowledge, valid while `done` is high.
  - Out form (`req_out`=1): `bus_wr` is 1 and `bus_wdata` equals the captured `wr_data`.
- R9: While a request is in progress, `req_valid` is ignored. Input changes after acceptance do not affect the transfer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Start a transfer (accepted in IDLE) |
| req_out | input | 1 | 1 = out form (write), 0 = in form (read) |
| req_ea | input | 32 | Effective address, used for the alignment check |
| req_pa | input | 32 | Translated physical address, the device operand |
| rid_reg | input | 32 | Resource ID register, low four bits used |
| seg_t | input | 1 | T bit of the addressed segment |
| dr_en | input | 1 | Data relocation enabled |
| wr_data | input | 32 | Store word for the out form |
| bus_req | output | 1 | Bus transfer request, held until acknowledge |
| bus_addr | output | 32 | Address operand passed to the device |
| bus_burst | output | 1 | Resource ID bit 3 |
| bus_size | output | 3 | Resource ID bits 2..0 |
| bus_wr | output | 1 | Write direction of the transfer |
| bus_wdata | output | 32 | Write word |
| bus_ack | input | 1 | Device acknowledge |
| bus_rdata | input | 32 | Device read word, sampled with the acknowledge |
| done | output | 1 | One-cycle completion pulse |
| rd_data | output | 32 | Word returned by the in form |
| exc_align | output | 1 | Alignment exception, pulses with done |
| exc_dsi | output | 1 | Data storage exception, pulses with done |

## Verification
The bench targets the following corner cases:
- Each nonzero low address pair (01, 10, 11). A design that tested only one bit of the address would let one of these through onto the bus.
- Misaligned and T-segment together. A design with the wrong priority, or with both flags set, would report a data storage fault.
- A resource ID with bit 3 set and with bit 3 clear. A design with the ID bits reversed or shifted would put the wrong value on the burst and size lines.
- An acknowledge delayed by several cycles, and input changes plus an extra `req_valid` pulse during a transfer. A design that did not hold the request, or re-sampled its inputs, would drop the transfer early, send altered data, or produce an extra completion.

// File: rtl/ecw_pkg.sv
package ecw_pkg;
    localparam int ADDR_W = 32;
    localparam int DATA_W = 32;
    localparam int RID_W  = 4;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_EVAL,
        ST_XFER,
        ST_FINISH,
        ST_FAULT
    } ecw_state_t;

    typedef struct packed {
        logic align;
        logic dsi;
    } ecw_exc_t;
endpackage

// File: rtl/ecw_check.sv
module ecw_check #(
    parameter int ADDR_W     = 32,
    parameter int ALIGN_BITS = 2
) (
    input  logic [ADDR_W-1:0] ea,
    input  logic              seg_t,
    output ecw_pkg::ecw_exc_t exc
);
    logic misaligned;

    assign misaligned = |ea[ALIGN_BITS-1:0];

    always_comb begin
        exc.align = misaligned;
        exc.dsi   = !misaligned && seg_t;
    end

    always_comb begin
        assert (!(exc.align && exc.dsi)); // R6
    end
endmodule

// File: rtl/ecw_busfmt.sv
module ecw_busfmt #(
    parameter int RID_W = 4
) (
    input  logic [RID_W-1:0] rid,
    output logic             burst,
    output logic [RID_W-2:0] size
);
    assign burst = rid[RID_W-1];
    assign size  = rid[RID_W-2:0];
endmodule

// File: rtl/ecw_unit.sv
module ecw_unit
    import ecw_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic              req_out,
    input  logic [ADDR_W-1:0] req_ea,
    input  logic [ADDR_W-1:0] req_pa,
    input  logic [31:0]       rid_reg,
    input  logic              seg_t,
    input  logic              dr_en,
    input  logic [DATA_W-1:0] wr_data,
    output logic              bus_req,
    output logic [ADDR_W-1:0] bus_addr,
    output logic              bus_burst,
    output logic [2:0]        bus_size,
    output logic              bus_wr,
    output logic [DATA_W-1:0] bus_wdata,
    input  logic              bus_ack,
    input  logic [DATA_W-1:0] bus_rdata,
    output logic              done,
    output logic [DATA_W-1:0] rd_data,
    output logic              exc_align,
    output logic              exc_dsi
);
    ecw_state_t        state_q, state_d;
    logic [ADDR_W-1:0] ea_q, pa_q;
    logic [RID_W-1:0]  rid_q;
    logic              segt_q, dr_q, out_q;
    logic [DATA_W-1:0] wdata_q, rdata_q;
    ecw_exc_t          exc_now, exc_q;
    logic              accept;

    assign accept = (state_q == ST_IDLE) && req_valid;

    ecw_check #(.ADDR_W(ADDR_W), .ALIGN_BITS(2)) u_check (
        .ea    (ea_q),
        .seg_t (segt_q),
        .exc   (exc_now)
    );

    ecw_busfmt #(.RID_W(RID_W)) u_fmt (
        .rid   (rid_q),
        .burst (bus_burst),
        .size  (bus_size)
    );

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:   if (req_valid) state_d = ST_EVAL;
            ST_EVAL:   state_d = (exc_now.align || exc_now.dsi) ? ST_FAULT : ST_XFER;
            ST_XFER:   if (bus_ack) state_d = ST_FINISH;
            ST_FINISH: state_d = ST_IDLE;
            ST_FAULT:  state_d = ST_IDLE;
            default:   state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ea_q    <= '0;
            pa_q    <= '0;
            rid_q   <= '0;
            segt_q  <= 1'b0;
            dr_q    <= 1'b0;
            out_q   <= 1'b0;
            wdata_q <= '0;
            rdata_q <= '0;
            exc_q   <= '0;
        end else begin
            if (accept) begin
                ea_q    <= req_ea;
                pa_q    <= req_pa;
                rid_q   <= rid_reg[RID_W-1:0];
                segt_q  <= seg_t;
                dr_q    <= dr_en;
                out_q   <= req_out;
                wdata_q <= wr_data;
            end
            if (state_q == ST_EVAL) exc_q <= exc_now;
            if (state_q == ST_XFER && bus_ack && !out_q) rdata_q <= bus_rdata;
        end
    end

    always_comb begin
        bus_req   = (state_q == ST_XFER);
        bus_addr  = dr_q ? pa_q : '0;
        bus_wr    = out_q;
        bus_wdata = wdata_q;
        done      = (state_q == ST_FINISH) || (state_q == ST_FAULT);
        rd_data   = rdata_q;
        exc_align = (state_q == ST_FAULT) && exc_q.align;
        exc_dsi   = (state_q == ST_FAULT) && exc_q.dsi;
    end

    AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        bus_req && !bus_ack |=> bus_req && $stable(bus_addr)); // R7
    AST_DONE_AFTER_ACK: assert property (@(posedge clk) disable iff (!rst_n)
        bus_req && bus_ack |=> done && !exc_align && !exc_dsi); // R7
    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done); // R7
    AST_EXC_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({exc_align, exc_dsi})); // R6
    AST_EXC_NO_BUS: assert property (@(posedge clk) disable iff (!rst_n)
        (exc_align || exc_dsi) |-> !bus_req && done); // R4
    AST_NO_REQ_AT_START: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(bus_req) |-> $past(state_q) == ST_EVAL); // R3
    AST_CAPTURE_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        bus_req && $past(bus_req) |-> $stable(bus_wdata) && $stable(bus_size)); // R9
endmodule

// File: tb/ecw_unit_tb.sv
module ecw_unit_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0, req_out = 1'b0, seg_t = 1'b0, dr_en = 1'b0;
    logic [31:0] req_ea = '0, req_pa = '0, rid_reg = '0, wr_data = '0;
    logic        bus_req, bus_burst, bus_wr, done, exc_align, exc_dsi;
    logic [31:0] bus_addr, bus_wdata, rd_data;
    logic [2:0]  bus_size;
    logic        bus_ack = 1'b0;
    logic [31:0] bus_rdata = '0;

    typedef struct {
        logic        f_align;
        logic        f_dsi;
        logic        uses_bus;
        logic        is_out;
        logic        chk_addr;
        logic [31:0] addr;
        logic [3:0]  rid;
        logic [31:0] wdata;
        logic [31:0] rdata;
        int          delay;
    } exp_t;

    exp_t exp_q[$];
    exp_t cur;
    int   checks = 0, fails = 0, done_cnt = 0;
    logic bus_seen = 1'b0;

    always #4 clk = ~clk;

    ecw_unit u_dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_out(req_out),
        .req_ea(req_ea), .req_pa(req_pa), .rid_reg(rid_reg), .seg_t(seg_t),
        .dr_en(dr_en), .wr_data(wr_data), .bus_req(bus_req), .bus_addr(bus_addr),
        .bus_burst(bus_burst), .bus_size(bus_size), .bus_wr(bus_wr),
        .bus_wdata(bus_wdata), .bus_ack(bus_ack), .bus_rdata(bus_rdata),
        .done(done), .rd_data(rd_data), .exc_align(exc_align), .exc_dsi(exc_dsi)
    );

    task automatic check(input bit ok, input string req, input logic [63:0] act,
                         input logic [63:0] expv);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, expv);
        end
    endtask

    // Driver: issue one request, push the expected result, then disturb inputs.
    task automatic issue(input logic dir, input logic [31:0] ea, input logic [31:0] pa,
                         input logic [31:0] rid, input logic t, input logic dr,
                         input logic [31:0] wd, input logic [31:0] rdv, input int dly);
        exp_t e;
        int   target;
        e.f_align  = (ea[1:0] != 2'b00);
        e.f_dsi    = (ea[1:0] == 2'b00) && t;
        e.uses_bus = !e.f_align && !e.f_dsi;
        e.is_out   = dir;
        e.chk_addr = dr;
        e.addr     = pa;
        e.rid      = rid[3:0];
        e.wdata    = wd;
        e.rdata    = rdv;
        e.delay    = dly;
        cur = e;
        exp_q.push_back(e);
        target = done_cnt + 1;
        @(negedge clk);
        req_out = dir; req_ea = ea; req_pa = pa; rid_reg = rid;
        seg_t = t; dr_en = dr; wr_data = wd; req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        // R9: scramble inputs after acceptance
        req_ea = 32'h0000_0003; req_pa = ~pa; rid_reg = ~rid; wr_data = ~wd;
        req_out = ~dir; seg_t = 1'b1;
        @(negedge clk);
        @(negedge clk);
        if (bus_req) begin
            // R9: a second request during the transfer must be ignored
            req_valid = 1'b1;
            @(negedge clk);
            req_valid = 1'b0;
        end
        while (done_cnt < target) @(negedge clk);
        @(negedge clk);
    endtask

    // Bus responder: checks the bus fields in the acknowledge cycle.
    initial begin
        int waitc;
        waitc = 0;
        forever begin
            @(negedge clk);
            if (bus_ack) begin
                bus_ack = 1'b0;
            end else if (bus_req) begin
                bus_seen = 1'b1;
                if (waitc >= cur.delay) begin
                    waitc = 0;
                    check(bus_burst == cur.rid[3], "R2 burst", 64'(bus_burst), 64'(cur.rid[3]));
                    check(bus_size == cur.rid[2:0], "R2 size", 64'(bus_size), 64'(cur.rid[2:0]));
                    if (cur.chk_addr)
                        check(bus_addr == cur.addr, "R3 addr", 64'(bus_addr), 64'(cur.addr));
                    check(bus_wr == cur.is_out, "R8 dir", 64'(bus_wr), 64'(cur.is_out));
                    if (cur.is_out)
                        check(bus_wdata == cur.wdata, "R8/R9 wdata", 64'(bus_wdata), 64'(cur.wdata));
                    bus_rdata = cur.rdata;
                    bus_ack = 1'b1;
                end else begin
                    waitc++;
                end
            end
        end
    end

    // Monitor: pops the scoreboard on every completion.
    initial begin
        exp_t e;
        forever begin
            @(negedge clk);
            if (rst_n && done) begin
                if (exp_q.size() == 0) begin
                    check(1'b0, "R9 unexpected done", 64'(1), 64'(0));
                end else begin
                    e = exp_q.pop_front();
                    check(exc_align == e.f_align, "R4/R6 exc_align", 64'(exc_align), 64'(e.f_align));
                    check(exc_dsi == e.f_dsi, "R5/R6 exc_dsi", 64'(exc_dsi), 64'(e.f_dsi));
                    check(bus_seen == e.uses_bus, "R3/R4/R5 bus used", 64'(bus_seen), 64'(e.uses_bus));
                    if (e.uses_bus && !e.is_out)
                        check(rd_data == e.rdata, "R8 rd_data", 64'(rd_data), 64'(e.rdata));
                end
                bus_seen = 1'b0;
                done_cnt++;
            end
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        check(!bus_req && !done && !exc_align && !exc_dsi, "R1 reset",
              64'({bus_req, done, exc_align, exc_dsi}), 64'(0));
        rst_n = 1'b1;
        @(negedge clk);
        issue(1'b0, 32'h1000_0010, 32'h0ABC_0010, 32'h0000_000A, 1'b0, 1'b1, 32'h0, 32'hDEAD_BEEF, 0); // R8 in
        issue(1'b1, 32'h1000_0020, 32'h0ABC_0020, 32'h0000_0005, 1'b0, 1'b1, 32'h1234_5678, 32'h0, 3); // R7 R8 out
        issue(1'b0, 32'h2000_0001, 32'h0, 32'h0000_0003, 1'b0, 1'b1, 32'h0, 32'h0, 0);    // R4
        issue(1'b1, 32'h2000_0002, 32'h0, 32'h0000_0003, 1'b0, 1'b1, 32'h5, 32'h0, 0);    // R4
        issue(1'b0, 32'h2000_0003, 32'h0, 32'h0000_0003, 1'b0, 1'b1, 32'h0, 32'h0, 0);    // R4
        issue(1'b0, 32'h3000_0004, 32'h0, 32'h0000_0009, 1'b1, 1'b1, 32'h0, 32'h0, 0);    // R5
        issue(1'b1, 32'h3000_0006, 32'h0, 32'h0000_0009, 1'b1, 1'b1, 32'h7, 32'h0, 0);    // R6
        issue(1'b0, 32'h4000_0040, 32'h5555_0040, 32'hFFFF_FFF8, 1'b0, 1'b0, 32'h0, 32'hCAFE_F00D, 5); // R3 dr off
        issue(1'b1, 32'h4000_0044, 32'h7777_0044, 32'h0000_000F, 1'b0, 1'b1, 32'hA5A5_5A5A, 32'h0, 1); // R2
        issue(1'b0, 32'h4000_0048, 32'h7777_0048, 32'h0000_0000, 1'b0, 1'b1, 32'h0, 32'h0BAD_CAFE, 2); // R2
        repeat (5) @(negedge clk);
        check(exp_q.size() == 0, "R9 pending items", 64'(exp_q.size()), 64'(0));
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog actual=hung expected=finish");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end
endmodule